// File: doc/BRIEF.md
# Exception Vector Catch Unit

This block watches the instruction fetch stream of a core. It asks the core's debug control to break when two things are true. First, a fetch is made from one of the eight exception vectors while the core is entering that exception. Second, software has armed that vector in an 8-bit catch register. The effect is the same as an instruction breakpoint on the vector address. It costs no watchpoint comparator, because the vector decoding is fixed logic of its own.

A fetch can only trigger when its exception-entry qualifier is high in the same cycle as the fetch strobe. The exception type code must also name the vector being fetched. As a result, an ordinary branch into the vector area never breaks. In monitor debug mode, the prefetch-abort and data-abort vectors are never caught. Taking a break there would trap the monitor in its own aborts. The vector table can sit at the low base (0x00000000) or at the high base (0xFFFF0000), selected by an input.

Top module: `vec_trap_unit`

## Requirements
- R1: After a cycle with `rst_n` low, `brk_req` is 0 and `catch_rdata` reads 0x00.
- R2: A cycle with `catch_we` high loads `catch_wdata` into the catch register. From the next cycle, `catch_rdata` returns the value with bit 5 forced to 0. Without `catch_we`, the register holds its value.
- R3: Slot n (0 to 7) is the vector at address base + 4*n. The slot order is: 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 reserved, 6 IRQ, 7 FIQ. Suppose `fetch_valid`, `exc_entry`, a matching address, `exc_kind` == n and catch bit n are all present at one clock edge. Then `brk_req` is high for the cycle after that edge, and only that cycle.
- R4: If catch bit n is 0 when the fetch is sampled, no request is made. A write in the same cycle as the fetch affects only later fetches.
- R5: A vector fetch with `exc_entry` low never asserts `brk_req`, whatever the catch bits say.
- R6: With `monitor_mode` = 1, slots 3 and 4 never trigger. The other slots still trigger under R3.
- R7: `high_vectors` = 0 selects base 0x00000000 and `high_vectors` = 1 selects base 0xFFFF0000. A vector address under the unselected base does not trigger.
- R8: The address must match exactly. Bits [1:0] must be 0, and bits [31:5] must equal the selected base. Any other address does not trigger.
- R9: A fetch whose `exc_kind` differs from the slot of its address does not trigger.
- R10: Slot 5 (reserved, offset 0x14) never triggers, even after writing 1 to bit 5.
- R11: With `fetch_valid` low, `brk_req` stays 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 32 | Instruction fetch address |
| fetch_valid | input | 1 | Fetch strobe |
| exc_entry | input | 1 | Fetch belongs to exception entry |
| exc_kind | input | 3 | Exception type code, equal to slot number |
| monitor_mode | input | 1 | 1 = monitor debug, 0 = halt debug |
| high_vectors | input | 1 | 1 selects high vector base |
| catch_we | input | 1 | Catch register write enable |
| catch_wdata | input | 8 | Catch register write data |
| catch_rdata | output | 8 | Catch register read value |
| brk_req | output | 1 | One-cycle instruction-breakpoint request |

## Verification
The hardest case to reach is a fetch where every trap condition holds except one. Examples are a vector fetch with the entry qualifier low, an abort vector in monitor mode, or a write that disarms a bit in the same cycle the vector is fetched. Purely random addresses almost never land on the vector table. The random stimulus therefore picks a base and slot first. It usually agrees the type code with the slot and sometimes corrupts the low address bits or uses the other base. Directed steps cover each near miss individually, as well as back-to-back qualifying fetches.

// File: rtl/vtu_pkg.sv
// Package: shared constants and types for the vector catch unit.
// Assumes an eight-entry vector table with word-spaced entries.
package vtu_pkg;
    localparam int unsigned VEC_COUNT = 8;
    localparam int unsigned SLOT_W    = $clog2(VEC_COUNT);
    typedef logic [SLOT_W-1:0] slot_t;

    // Slots with behaviour of their own.
    localparam int unsigned SLOT_PABT = 3;
    localparam int unsigned SLOT_DABT = 4;
    localparam int unsigned SLOT_RSVD = 5;
endpackage

// File: rtl/vtu_catch_reg.sv
// Module: catch register. Holds one arm bit per vector slot. Writes happen
// through a plain enable/data port. The reserved slot is tied to zero.
// Assumes synchronous active-low reset and writes that take effect at the edge.
module vtu_catch_reg
    import vtu_pkg::*;
#(
    parameter int unsigned N_SLOTS = VEC_COUNT,
    parameter int unsigned RSVD    = SLOT_RSVD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [N_SLOTS-1:0] wdata,
    output logic [N_SLOTS-1:0] arm_q
);
    logic [N_SLOTS-1:0] keep;

    // Build the writable-bit mask; the reserved slot stays clear.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_keep
        if (i == RSVD) begin : g_rsvd
            assign keep[i] = 1'b0;
        end else begin : g_norm
            assign keep[i] = 1'b1;
        end
    end

    // Register update: clear on reset, load masked data on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (we) begin
            arm_q <= wdata & keep;
        end
    end

    // R2: the register only changes on a write.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(arm_q));
endmodule

// File: rtl/vtu_vec_decode.sv
// Module: vector address decoder. Reports whether a fetch address is a vector
// table entry under the selected base and, if so, which slot it is.
// Assumes word-aligned entries at base + 4*slot.
module vtu_vec_decode
    import vtu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              high_sel,
    output logic              is_vec,
    output slot_t             slot
);
    localparam int unsigned LSB = SLOT_W + 2;
    localparam logic [ADDR_W-LSB-1:0] HI_TAG = HIGH_BASE[ADDR_W-1:LSB];

    logic [ADDR_W-LSB-1:0] tag_sel;

    // Pick the tag of the selected base and compare the address exactly.
    always_comb begin
        tag_sel = high_sel ? HI_TAG : '0;
        is_vec  = (fetch_addr[ADDR_W-1:LSB] == tag_sel) && (fetch_addr[1:0] == 2'b00);
        slot    = fetch_addr[LSB-1:2];
    end
endmodule

// File: rtl/vtu_trap_gen.sv
// Module: trap qualifier. Combines the decode result, the entry qualifier,
// the type code, the arm bits and the monitor-mode mask. Drives a
// registered one-cycle breakpoint request.
// Assumes the qualifier and type code are valid in the fetch cycle.
module vtu_trap_gen
    import vtu_pkg::*;
#(
    parameter int unsigned N_SLOTS = VEC_COUNT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic               exc_entry,
    input  slot_t              exc_kind,
    input  logic               monitor_mode,
    input  logic               is_vec,
    input  slot_t              slot,
    input  logic [N_SLOTS-1:0] arm_bits,
    output logic               brk_req
);
    logic [N_SLOTS-1:0] mon_block;
    logic [N_SLOTS-1:0] arm_eff;
    logic               hit;

    // Mark the slots that monitor mode must never catch.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_mask
        if (i == SLOT_PABT || i == SLOT_DABT) begin : g_abort
            assign mon_block[i] = 1'b1;
        end else begin : g_other
            assign mon_block[i] = 1'b0;
        end
    end

    // Effective arming after the monitor mask, then full trap qualification.
    always_comb begin
        arm_eff = arm_bits & ~(mon_block & {N_SLOTS{monitor_mode}});
        hit     = fetch_valid && exc_entry && is_vec && (slot == exc_kind) && arm_eff[slot];
    end

    // Register the request so it lasts one cycle per qualifying fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_req <= 1'b0;
        end else begin
            brk_req <= hit;
        end
    end

    // R5 and R11: a request follows only a strobed entry fetch.
    p_entry_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(fetch_valid && exc_entry));
    // R3: a request follows only an armed slot.
    p_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(arm_bits[slot]));
    // R9: the type code matched the decoded slot.
    p_kind_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(exc_kind == slot));
    // R6: no abort catch in monitor mode.
    p_mon_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(monitor_mode)) |->
            ($past(slot) != slot_t'(SLOT_PABT) && $past(slot) != slot_t'(SLOT_DABT)));
    // R10: the reserved slot never triggers.
    p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(slot) != slot_t'(SLOT_RSVD));
endmodule

// File: rtl/vec_trap_unit.sv
// Module: exception vector catch unit top. Connects the catch register,
// the vector decoder and the trap qualifier.
// Assumes a 32-bit fetch address and a type code equal to the slot number.
module vec_trap_unit
    import vtu_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_valid,
    input  logic              exc_entry,
    input  logic [SLOT_W-1:0] exc_kind,
    input  logic              monitor_mode,
    input  logic              high_vectors,
    input  logic              catch_we,
    input  logic [VEC_COUNT-1:0] catch_wdata,
    output logic [VEC_COUNT-1:0] catch_rdata,
    output logic              brk_req
);
    logic [VEC_COUNT-1:0] arm_q;
    logic                 is_vec;
    slot_t                slot;

    vtu_catch_reg #(.N_SLOTS(VEC_COUNT), .RSVD(SLOT_RSVD)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (catch_we),
        .wdata (catch_wdata),
        .arm_q (arm_q)
    );

    vtu_vec_decode #(.ADDR_W(ADDR_W), .HIGH_BASE(HIGH_BASE)) u_dec (
        .fetch_addr (fetch_addr),
        .high_sel   (high_vectors),
        .is_vec     (is_vec),
        .slot       (slot)
    );

    vtu_trap_gen #(.N_SLOTS(VEC_COUNT)) u_trap (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .exc_entry    (exc_entry),
        .exc_kind     (exc_kind),
        .monitor_mode (monitor_mode),
        .is_vec       (is_vec),
        .slot         (slot),
        .arm_bits     (arm_q),
        .brk_req      (brk_req)
    );

    // Read port shows the stored arm bits.
    assign catch_rdata = arm_q;
endmodule

// File: tb/test_vec_trap_unit.sv
module test_vec_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_addr;
    logic        fetch_valid, exc_entry, monitor_mode, high_vectors, catch_we;
    logic [2:0]  exc_kind;
    logic [7:0]  catch_wdata, catch_rdata;
    logic        brk_req;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [7:0] model_arm = 8'h00;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    vec_trap_unit i_vec_trap_unit (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .exc_entry(exc_entry), .exc_kind(exc_kind), .monitor_mode(monitor_mode),
        .high_vectors(high_vectors), .catch_we(catch_we), .catch_wdata(catch_wdata),
        .catch_rdata(catch_rdata), .brk_req(brk_req)
    );

    // Expected request from the requirements (R3..R11).
    function automatic logic exp_trap(input logic [7:0] arm, input logic [31:0] a,
                                      input logic v, input logic e, input logic [2:0] k,
                                      input logic m, input logic h);
        logic [31:0] base;
        logic [2:0]  s;
        base = h ? 32'hFFFF_0000 : 32'h0;
        if (!(v && e)) return 1'b0;
        if (a[31:5] != base[31:5] || a[1:0] != 2'b00) return 1'b0;
        s = a[4:2];
        if (s != k) return 1'b0;
        if (s == 3'd5) return 1'b0;
        if (m && (s == 3'd3 || s == 3'd4)) return 1'b0;
        return arm[s];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; checks request and readback after the edge.
    task automatic step(input logic [31:0] a, input logic v, input logic e,
                        input logic [2:0] k, input logic m, input logic h,
                        input logic we, input logic [7:0] wd, input string tag);
        logic exp_b;
        @(negedge clk);
        fetch_addr = a; fetch_valid = v; exc_entry = e; exc_kind = k;
        monitor_mode = m; high_vectors = h; catch_we = we; catch_wdata = wd;
        exp_b = exp_trap(model_arm, a, v, e, k, m, h);
        @(posedge clk);
        if (we) model_arm = wd & 8'hDF;
        #1;
        chk(tag, {31'd0, brk_req}, {31'd0, exp_b});
        chk({tag, " R2 readback"}, {24'd0, catch_rdata}, {24'd0, model_arm});
    endtask

    task automatic idle(input string tag);
        step(32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    task automatic wr(input logic [7:0] d);
        step(32'h0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, d, "R2 write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; fetch_addr = '0; fetch_valid = 0; exc_entry = 0; exc_kind = 0;
        monitor_mode = 0; high_vectors = 0; catch_we = 0; catch_wdata = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 brk_req", {31'd0, brk_req}, 32'd0);
        chk("R1 rdata", {24'd0, catch_rdata}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        wr(8'hFF);                                           // R2: bit 5 reads 0
        chk("R2 rsvd bit", {24'd0, catch_rdata}, 32'hDF);
        step(32'h08, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R3 swi trap");
        idle("R3 one cycle");
        step(32'h08, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R3 back-to-back a");
        step(32'h18, 1, 1, 3'd6, 0, 0, 0, 8'h0, "R3 back-to-back b");
        step(32'h08, 1, 0, 3'd2, 0, 0, 0, 8'h0, "R5 branch to vector");
        step(32'h08, 0, 1, 3'd2, 0, 0, 0, 8'h0, "R11 no strobe");
        step(32'h0C, 1, 1, 3'd3, 1, 0, 0, 8'h0, "R6 pabt masked");
        step(32'h10, 1, 1, 3'd4, 1, 0, 0, 8'h0, "R6 dabt masked");
        step(32'h08, 1, 1, 3'd2, 1, 0, 0, 8'h0, "R6 swi in monitor");
        step(32'h0C, 1, 1, 3'd3, 0, 0, 0, 8'h0, "R6 pabt halt mode");
        step(32'hFFFF0008, 1, 1, 3'd2, 0, 1, 0, 8'h0, "R7 high base");
        step(32'h08, 1, 1, 3'd2, 0, 1, 0, 8'h0, "R7 low addr high sel");
        step(32'hFFFF0008, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R7 high addr low sel");
        step(32'h09, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R8 misaligned");
        step(32'h108, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R8 upper bits");
        step(32'h08, 1, 1, 3'd3, 0, 0, 0, 8'h0, "R9 kind mismatch");
        step(32'h14, 1, 1, 3'd5, 0, 0, 0, 8'h0, "R10 reserved slot");
        wr(8'hFB);
        step(32'h08, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R4 disarmed");
        step(32'h08, 1, 1, 3'd2, 0, 0, 1, 8'hFF, "R4 same-cycle write");
        step(32'h08, 1, 1, 3'd2, 0, 0, 0, 8'h0, "R4 rearmed");

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [2:0]  s, k;
            logic        h, hsel;
            s = 3'($urandom_range(0, 7));
            h = 1'($urandom_range(0, 1));
            hsel = ($urandom_range(0, 9) < 8) ? h : ~h;
            a = (h ? 32'hFFFF_0000 : 32'h0) | {27'd0, s, 2'b00};
            if ($urandom_range(0, 9) == 0) a[1:0] = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 19) == 0) a = $urandom;
            k = ($urandom_range(0, 9) < 7) ? s : 3'($urandom_range(0, 7));
            step(a, ($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 7), k,
                 1'($urandom_range(0, 1)), hsel, ($urandom_range(0, 9) == 0),
                 8'($urandom), "R3/R4 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule